// File: doc/BRIEF.md
# Fractional M/N Clock Rate Generator

This block turns a parent clock into a train of single-cycle enable pulses. The average pulse rate is the parent rate divided by an integer pre-divider, then scaled by a fraction M/N. Logic downstream uses the enable to run at the lower rate while staying in the parent clock domain.

Software programs the block through two register words. The control word holds the source select, the pre-divider, the encoded N, the counter mode, the counter enable and a counter hold bit. The fraction word holds M and the inverse of N. The values are stored in offset and inverted form. Software sets the hold bit while it loads new M/N values and clears it to restart the fractional counter from zero.

Top module: `mnd_rate_gen`

## Requirements
- R1: The control word (address 0) has these fields with default widths: source select in bits [2:0], pre-divider in [6:3], hold in bit 7, counter enable in bit 8, counter mode in [10:9], and the encoded N in [23:16]. The effective N is (bitwise inverse of the encoded field + M) modulo 2^CNT_W.
- R2: The fraction word (address 1) carries M in bits [23:16]. Its low CNT_W bits store the inverse of N, which software writes and reads back, and they play no part in the rate.
- R3: A pre-divider field value p produces one internal tick every p+1 parent cycles.
- R4: When the mode field is nonzero, the enable bit is set and the effective N is nonzero, the block emits exactly M pulses per N ticks. The accumulator adds M on each tick, emits a pulse when the sum is N or more, and subtracts N at that point. M must not exceed N.
- R5: When the mode field is zero or the enable bit is clear, every tick is a pulse, so only the pre-divider applies.
- R6: Programming N=0 leaves the encoded N, M, enable and mode all zero, and the output then follows the pre-divider alone.
- R7: While the hold bit is set with the fractional stage active, no pulse is emitted and the accumulator stays at zero. When the bit is cleared, counting restarts from zero.
- R8: A read at either address returns exactly the last word written there.
- R9: Any register write restarts the pre-divider phase and forces the enable output low in the following cycle.
- R10: During reset both words read zero and the enable output is low.
- R11: The source-select output follows control bits [2:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write address: 0 control word, 1 fraction word |
| wrData | input | 32 | Write data |
| rdAddr | input | 1 | Read address |
| rdData | output | 32 | Read data, combinational |
| srcSel | output | 3 | Selected source index |
| clkEn | output | 1 | Rate enable pulse |

## Verification
A corrupted accumulator or pre-divider count changes the pulse pattern on clkEn within one tick period. An error in decoding N or M shifts the pulse count over a window of ten N ticks away from ten M. The reference model predicts clkEn every cycle, so the first wrong pulse is reported at the cycle where it occurs. Readback exposes any field that is mangled on storage as soon as it is read.

// File: rtl/mnd_pkg.sv
package mnd_pkg;
  typedef struct packed {
    logic restart;
    logic hold;
    logic mnOn;
  } mndStrobe_t;
endpackage

// File: rtl/mnd_ctrl.sv
module mnd_ctrl
  import mnd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 8,
  parameter int PRE_W    = 4,
  parameter int SRC_W    = 3,
  parameter int NFLD_LSB = 16,
  parameter int MFLD_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [SRC_W-1:0]  srcSel,
  output logic [CNT_W-1:0]  mVal,
  output logic [CNT_W-1:0]  nVal,
  output logic [PRE_W-1:0]  preDiv,
  output mndStrobe_t        strb
);
  localparam int PRE_LSB  = SRC_W;
  localparam int HOLD_BIT = PRE_LSB + PRE_W;
  localparam int EN_BIT   = HOLD_BIT + 1;
  localparam int MODE_LSB = EN_BIT + 1;

  logic [DATA_W-1:0] nsReg, mdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nsReg <= '0;
      mdReg <= '0;
    end else if (wrEn) begin
      if (wrAddr) mdReg <= wrData;
      else        nsReg <= wrData;
    end
  end

  assign rdData = rdAddr ? mdReg : nsReg;
  assign srcSel = nsReg[SRC_W-1:0];
  assign preDiv = nsReg[PRE_LSB +: PRE_W];
  assign mVal   = mdReg[MFLD_LSB +: CNT_W];
  assign nVal   = ~nsReg[NFLD_LSB +: CNT_W] + mVal;

  always_comb begin
    strb.restart = wrEn;
    strb.hold    = nsReg[HOLD_BIT];
    strb.mnOn    = (|nsReg[MODE_LSB +: 2]) & nsReg[EN_BIT] & (|nVal);
  end
endmodule

// File: rtl/mnd_datapath.sv
module mnd_datapath
  import mnd_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  mndStrobe_t       strb,
  input  logic [CNT_W-1:0] mVal,
  input  logic [CNT_W-1:0] nVal,
  input  logic [PRE_W-1:0] preDiv,
  output logic             tick,
  output logic [CNT_W-1:0] accVal,
  output logic             clkEn
);
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W:0]   sum;
  logic             sumHit;

  assign tick   = (preCnt >= preDiv);
  assign sum    = {1'b0, accVal} + {1'b0, mVal};
  assign sumHit = (sum >= {1'b0, nVal});

  always_ff @(posedge clk) begin
    if (!rstN || strb.restart || tick) preCnt <= '0;
    else                               preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strb.mnOn || strb.hold) accVal <= '0;
    else if (tick) begin
      if (sumHit) accVal <= CNT_W'(sum - {1'b0, nVal});
      else        accVal <= sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.restart) clkEn <= 1'b0;
    else if (strb.mnOn)        clkEn <= !strb.hold && tick && sumHit;
    else                       clkEn <= tick;
  end
endmodule

// File: rtl/mnd_rate_gen.sv
module mnd_rate_gen
  import mnd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 8,
  parameter int PRE_W    = 4,
  parameter int SRC_W    = 3,
  parameter int NFLD_LSB = 16,
  parameter int MFLD_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [SRC_W-1:0]  srcSel,
  output logic              clkEn
);
  mndStrobe_t       strb;
  logic [CNT_W-1:0] mVal, nVal, accVal;
  logic [PRE_W-1:0] preDiv;
  logic             tick;

  mnd_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W), .SRC_W(SRC_W),
    .NFLD_LSB(NFLD_LSB), .MFLD_LSB(MFLD_LSB)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .srcSel(srcSel), .mVal(mVal),
    .nVal(nVal), .preDiv(preDiv), .strb(strb)
  );

  mnd_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mVal(mVal), .nVal(nVal),
    .preDiv(preDiv), .tick(tick), .accVal(accVal), .clkEn(clkEn)
  );
endmodule

// File: rtl/mnd_rate_gen_chk.sv
module mnd_rate_gen_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              clkEn,
  input logic              hold,
  input logic              mnOn,
  input logic              tick,
  input logic [CNT_W-1:0]  accVal
);
  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (mnOn && hold) |=> !clkEn); // R7
  AST_HOLD_ACC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> (accVal == '0)); // R7
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !clkEn); // R9
  AST_BYPASS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!mnOn && tick && !wrEn) |=> clkEn); // R5
  AST_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn) && ($past(wrAddr) == rdAddr) && $stable(rdAddr)) |-> (rdData == $past(wrData))); // R8
endmodule

bind mnd_rate_gen mnd_rate_gen_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddr(rdAddr), .rdData(rdData), .clkEn(clkEn), .hold(strb.hold),
  .mnOn(strb.mnOn), .tick(tick), .accVal(accVal)
);

// File: tb/tb_mnd_rate_gen.sv
module tb_mnd_rate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 8;
  localparam int PW   = 4;
  localparam int MASK = (1 << CW) - 1;

  logic        clk = 0, rstN = 0, wrEn = 0, wrAddr = 0, rdAddr = 0;
  logic [31:0] wrData = 0;
  wire  [31:0] rdData;
  wire  [2:0]  srcSel;
  wire         clkEn;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  mnd_rate_gen dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .srcSel(srcSel), .clkEn(clkEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model, one step per clock edge
  logic [31:0] mNs = 0, mMd = 0;
  int mPre = 0, mAcc = 0;
  bit mOut = 0;
  always @(posedge clk) begin : model
    int p, m, effN, sum;
    bit on, hold, tk, nOut;
    if (!rstN) begin
      mNs = 0; mMd = 0; mPre = 0; mAcc = 0; mOut = 0;
    end else begin
      p    = int'(mNs[6:3]);
      m    = int'(mMd[23:16]);
      effN = ((~int'(mNs[23:16]) & MASK) + m) & MASK;
      on   = (mNs[10:9] != 0) && mNs[8] && (effN != 0);
      hold = mNs[7];
      tk   = (mPre >= p);
      sum  = mAcc + m;
      if (wrEn)    nOut = 0;
      else if (on) nOut = !hold && tk && (sum >= effN);
      else         nOut = tk;
      if (!on || hold) mAcc = 0;
      else if (tk) mAcc = (sum >= effN) ? ((sum - effN) & MASK) : sum;
      if (wrEn || tk) mPre = 0; else mPre = mPre + 1;
      mOut = nOut;
      if (wrEn) begin
        if (wrAddr) mMd = wrData; else mNs = wrData;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (clkEn !== mOut) begin
        failures++;
        if (failures < 10)
          $display("FAIL R4/R5 per-cycle model actual=%0b expected=%0b at cycle %0d", clkEn, mOut, cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] encNs(int src, int p, int m, int n, bit hold, int mode);
    logic [31:0] v = 0;
    v[2:0] = src[2:0];
    v[6:3] = p[3:0];
    v[7]   = hold;
    if (n != 0) begin
      v[8]     = 1'b1;
      v[10:9]  = mode[1:0];
      v[23:16] = ~(n[7:0] - m[7:0]);
    end
    return v;
  endfunction

  function automatic logic [31:0] encMd(int m, int n);
    logic [31:0] v = 0;
    if (n != 0) begin
      v[23:16] = m[7:0];
      v[7:0]   = ~n[7:0];
    end
    return v;
  endfunction

  task automatic wr(bit a, logic [31:0] d);
    wrAddr = a; wrData = d; wrEn = 1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic countWin(int w, output int c);
    c = 0;
    repeat (w) begin
      @(negedge clk);
      c += int'(clkEn);
    end
  endtask

  task automatic runCase(string req, int src, int p, int m, int n, int mode, int w, int expCnt);
    int c;
    wr(0, encNs(src, p, m, n, 1, mode));
    wr(1, encMd(m, n));
    wr(0, encNs(src, p, m, n, 0, mode));
    rdAddr = 0; #1;
    check({req, " R8 R1 control readback"}, rdData, encNs(src, p, m, n, 0, mode));
    rdAddr = 1; #1;
    check({req, " R8 R2 fraction readback"}, rdData, encMd(m, n));
    check({req, " R11 source select"}, srcSel, src);
    countWin(w, c);
    check({req, " pulse count"}, c, expCnt);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    check("R10 reset clkEn", clkEn, 0);
    rdAddr = 0; #1; check("R10 reset control word", rdData, 0);
    rdAddr = 1; #1; check("R10 reset fraction word", rdData, 0);
    rstN = 1;
    @(negedge clk);
    // R4: ten N ticks give ten M pulses
    runCase("R4 p0 M1 N3",   1, 0, 1, 3,   2, 30,   10);
    runCase("R4 R3 p2 M3 N8", 2, 2, 3, 8,   2, 240,  30);
    runCase("R4 p1 M5 N5",   3, 1, 5, 5,   2, 100,  50);
    runCase("R4 p0 M7 N200", 4, 0, 7, 200, 2, 2000, 70);
    runCase("R4 p3 M0 N6",   5, 3, 0, 6,   2, 240,  0);
    runCase("R4 mode1 p1 M2 N7", 6, 1, 2, 7, 1, 140, 20);
    // R6 and R3: N=0 leaves only the pre-divider
    runCase("R6 R3 p3 N0", 7, 3, 0, 0, 2, 160, 40);
    // R5: enable set but mode zero
    runCase("R5 mode0 p2 M1 N4", 0, 2, 1, 4, 0, 120, 40);
    // R7: hold freezes the fractional counter
    wr(0, encNs(0, 0, 1, 2, 1, 2));
    wr(1, encMd(1, 2));
    countWin(60, c);
    check("R7 no pulses while held", c, 0);
    wr(0, encNs(0, 0, 1, 2, 0, 2));
    countWin(20, c);
    check("R7 restart after release", c, 10);
    // R9: a write silences the next cycle, pre-divider p=0 bypass
    wr(0, encNs(0, 0, 0, 0, 0, 0));
    @(negedge clk);
    check("R9 bypass running", clkEn, 1);
    wr(1, 32'h0);
    check("R9 output low after write", clkEn, 0);
    @(negedge clk);
    check("R9 resumes next cycle", clkEn, 1);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule